// File: doc/BRIEF.md
# Multi-Mode Variable-Length Timer Counter

This block is a free-standing timer counter driven by one system clock. One of four synchronous enable-pulse inputs is chosen as the counting source. A prescaler divides that source by 1, 2, 4 or 8, and each divided tick advances a 16-bit counter. The counter has four modes: halted, counting up to a compare value, free-running up to a selectable length limit, or bouncing between zero and the compare value. The free-running limit can be 8, 10, 12 or 16 bits.

Software drives the block through a single control word. The word sets the mode, length, prescale, source, interrupt enable and the sticky wrap flag. It also carries a self-clearing restart bit. The compare value comes in on its own port from an external compare latch. The outputs are the count, the counting direction, the wrap flag and a gated interrupt.

Top module: `mm_timer`

## Requirements
- R1: After reset, the count is 0, the control word reads back as 0, the wrap flag, the interrupt and the down indication are 0, and the counter is halted.
- R2: With mode code 00 in control bits [1:0], the count holds its value whatever pulses arrive on any source.
- R3: With mode code 01, each divided tick adds one to the count. A tick taken while the count is equal to or above `top_val` returns the count to 0.
- R4: With mode code 10, the count wraps from its limit to 0. The limit comes from control bits [3:2]: 00 gives 0xFFFF, 01 gives 0x0FFF, 10 gives 0x03FF and 11 gives 0x00FF.
- R5: Control bits [5:4], codes 00, 01, 10 and 11, give one counter tick per 1, 2, 4 or 8 pulses of the selected source, counted from the last restart.
- R6: The wrap flag (control bit 9) sets whenever the count returns to 0: on the wrap in modes 01 and 10, and on reaching 0 while descending in mode 11. It stays set until software writes 0 to bit 9. A hardware set wins over a write in the same cycle.
- R7: Control bits [7:6] select which bit of `src_tick` drives the prescaler. Pulses on the other three bits have no effect on the count.
- R8: With mode code 11, the count rises from 0 to `top_val` and then falls back to 0. `count_down` is 1 exactly while the count is falling.
- R9: Writing 1 to control bit 10 sets the count to 0, restarts the prescaler and sets the direction to up, in the cycle of the write. Bit 10 always reads back as 0.
- R10: `irq` is 1 exactly when the wrap flag and the interrupt enable (control bit 8) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Enable pulses of the four counting sources |
| top_val | input | 16 | Compare value that bounds up and up/down modes |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 11 | Control word write data |
| cfg_rd | output | 11 | Control word read-back (restart bit reads 0) |
| count | output | 16 | Current counter value |
| count_down | output | 1 | High while counting down in up/down mode |
| ovf_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Wrap flag gated by interrupt enable |

## Verification
The embedded properties assume that `src_tick` pulses are synchronous single-cycle enables. They also assume that `top_val` changes only between ticks. The stepping checks condition on the compare value present in the same cycle, so they stay valid when the value moves. The stimulus drives every input on the falling clock edge. It changes the compare value only while the source is idle, and it restarts the counter with the clear bit before each sweep, so the direction register always starts from a known state.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;
  typedef enum logic [1:0] {
    MD_STOP = 2'b00,
    MD_UP   = 2'b01,
    MD_CONT = 2'b10,
    MD_UPDN = 2'b11
  } mode_e;

  // control word, MSB first
  typedef struct packed {
    logic       clr;
    logic       flag;
    logic       ie;
    logic [1:0] src;
    logic [1:0] div;
    logic [1:0] len;
    mode_e      mode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mmt_tick_gen.sv
`timescale 1ns/1ps
module mmt_tick_gen #(
  parameter int NSRC  = 4,
  parameter int DIV_W = 3
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic [NSRC-1:0]         src_tick,
  input  logic [$clog2(NSRC)-1:0] src_sel,
  input  logic [1:0]              div_code,
  input  logic                    run,
  input  logic                    clr,
  output logic                    tick
);
  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             sel;

  always_comb begin
    sel   = src_tick[src_sel] & run;
    mask  = ~({DIV_W{1'b1}} << div_code);
    tick  = sel && ((div_q & mask) == mask);
    div_d = div_q;
    if (clr)      div_d = '0;
    else if (sel) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) div_q <= '0;
    else         div_q <= div_d;
  end

  // R5
  div_gap_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && div_code != 2'd0 && !clr) |=> (!tick || div_code != $past(div_code)));
endmodule

// File: rtl/mmt_count_core.sv
`timescale 1ns/1ps
module mmt_count_core
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             clr,
  input  mode_e            mode,
  input  logic [1:0]       len,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             down,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             dn_q, dn_d;

  always_comb begin
    case (len)
      2'd0:    lim = {CNT_W{1'b1}};
      2'd1:    lim = {CNT_W{1'b1}} >> 4;
      2'd2:    lim = {CNT_W{1'b1}} >> 6;
      default: lim = {CNT_W{1'b1}} >> 8;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    wrap  = 1'b0;
    if (mode != MD_UPDN) dn_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      case (mode)
        MD_UP: begin
          if (cnt_q >= top) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        MD_CONT: begin
          if (cnt_q >= lim) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        MD_UPDN: begin
          if (!dn_q && cnt_q < top) begin
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == '0) begin
            dn_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
              dn_d = 1'b0;
              wrap = 1'b1;
            end else dn_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign count = cnt_q;
  assign down  = dn_q;

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (cnt_q == '0 && !dn_q));
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == MD_STOP && !clr) |=> $stable(cnt_q));
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && !clr && mode == MD_UP && cnt_q < top) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && !clr && mode == MD_CONT && cnt_q == lim) |=> cnt_q == '0);
  // R8
  updn_fall_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && !clr && mode == MD_UPDN && dn_q) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mm_timer.sv
`timescale 1ns/1ps
module mm_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSRC  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           src_tick,
  input  logic [CNT_W-1:0]          top_val,
  input  logic                      cfg_we,
  input  logic [mmt_pkg::CFG_W-1:0] cfg_wdata,
  output logic [mmt_pkg::CFG_W-1:0] cfg_rd,
  output logic [CNT_W-1:0]          count,
  output logic                      count_down,
  output logic                      ovf_flag,
  output logic                      irq
);
  logic [1:0] rs_q;
  logic       arst_n;
  cfg_t       cfg_q, cfg_d, wr_cfg;
  logic       clr_pulse, tick, wrap;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  always_comb begin
    wr_cfg    = cfg_t'(cfg_wdata);
    clr_pulse = cfg_we & wr_cfg.clr;
    cfg_d     = cfg_q;
    if (cfg_we) cfg_d = wr_cfg;
    cfg_d.clr = 1'b0;
    if (wrap) cfg_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  mmt_tick_gen #(.NSRC(NSRC), .DIV_W(3)) u_tick (
    .clk      (clk),
    .arst_n   (arst_n),
    .src_tick (src_tick),
    .src_sel  (cfg_q.src[$clog2(NSRC)-1:0]),
    .div_code (cfg_q.div),
    .run      (cfg_q.mode != MD_STOP),
    .clr      (clr_pulse),
    .tick     (tick)
  );

  mmt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (tick),
    .clr    (clr_pulse),
    .mode   (cfg_q.mode),
    .len    (cfg_q.len),
    .top    (top_val),
    .count  (count),
    .down   (count_down),
    .wrap   (wrap)
  );

  assign cfg_rd   = cfg_q;
  assign ovf_flag = cfg_q.flag;
  assign irq      = cfg_q.flag & cfg_q.ie;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wrap |=> ovf_flag);
  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (ovf_flag && !cfg_we) |=> ovf_flag);
endmodule

// File: tb/sim_mm_timer.sv
`timescale 1ns/1ps
module sim_mm_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_tick;
  logic [15:0] top_val;
  logic        cfg_we;
  logic [10:0] cfg_wdata;
  logic [10:0] cfg_rd;
  logic [15:0] count;
  logic        count_down, ovf_flag, irq;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mm_timer u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .top_val(top_val),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .count(count),
    .count_down(count_down), .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic logic [10:0] cw(input int md, input int ln, input int dv,
                                     input int sr, input bit ie, input bit fl,
                                     input bit cl);
    return {cl, fl, ie, 2'(sr), 2'(dv), 2'(ln), 2'(md)};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick = m;
    end
    @(negedge clk); src_tick = 4'h0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_tick = 4'h0; top_val = 16'd0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 cfg_rd", cfg_rd, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 down", count_down, 0);

    // R2 halted mode ignores all sources
    run(4'hF, 6);
    chk("R2 stop count", count, 0);

    // R3 up mode sweep, R6 flag on wrap
    top_val = 16'd5;
    wr(cw(1, 0, 0, 0, 0, 0, 1));
    for (int n = 1; n <= 14; n++) begin
      run(4'h1, 1);
      chk("R3 up count", count, n % 6);
      chk("R6 up flag", ovf_flag, (n >= 6) ? 1 : 0);
    end

    // R3 compare value lowered below the count
    top_val = 16'd9;
    wr(cw(1, 0, 0, 0, 0, 0, 1));
    run(4'h1, 7);
    chk("R3 pre-lower", count, 7);
    top_val = 16'd3;
    run(4'h1, 1);
    chk("R3 above top wraps", count, 0);
    chk("R6 flag after lowered wrap", ovf_flag, 1);

    // R4 continuous mode, all lengths
    for (int lc = 0; lc < 4; lc++) begin
      int lim;
      lim = 16'hFFFF >> ((lc == 0) ? 0 : (lc == 1) ? 4 : (lc == 2) ? 6 : 8);
      wr(cw(2, lc, 0, 0, 0, 0, 1));
      run(4'h1, lim);
      chk("R4 at limit", count, lim);
      chk("R6 no flag before wrap", ovf_flag, 0);
      run(4'h1, 1);
      chk("R4 wrapped", count, 0);
      chk("R6 flag on cont wrap", ovf_flag, 1);
      run(4'h1, 1);
      chk("R4 after wrap", count, 1);
    end

    // R5 prescaler sweep
    top_val = 16'hFFFF;
    for (int d = 0; d < 4; d++) begin
      wr(cw(1, 0, d, 0, 0, 0, 1));
      for (int k = 1; k <= 13; k++) begin
        run(4'h1, 1);
        chk("R5 divided count", count, k >> d);
      end
    end

    // R7 source selection
    for (int s = 0; s < 4; s++) begin
      wr(cw(1, 0, 0, s, 0, 0, 1));
      run(~(4'h1 << s), 5);
      chk("R7 other sources ignored", count, 0);
      run(4'h1 << s, 3);
      chk("R7 selected source counts", count, 3);
    end

    // R8 up/down sweep
    top_val = 16'd4;
    wr(cw(3, 0, 0, 0, 0, 0, 1));
    for (int n = 1; n <= 20; n++) begin
      int p;
      p = n % 8;
      run(4'h1, 1);
      chk("R8 updn count", count, (p <= 4) ? p : 8 - p);
      chk("R8 updn dir", count_down, (p > 4) ? 1 : 0);
      chk("R6 updn flag", ovf_flag, (n >= 8) ? 1 : 0);
    end

    // R9 clear: count, prescaler, direction, read-back
    top_val = 16'd100;
    wr(cw(1, 0, 2, 0, 0, 0, 1));
    run(4'h1, 6);
    chk("R9 pre-clear count", count, 1);
    wr(cw(1, 0, 2, 0, 0, 0, 1));
    chk("R9 count cleared", count, 0);
    chk("R9 clear bit reads 0", cfg_rd, cw(1, 0, 2, 0, 0, 0, 0));
    run(4'h1, 3);
    chk("R9 prescaler restarted", count, 0);
    run(4'h1, 1);
    chk("R9 first tick after restart", count, 1);
    top_val = 16'd4;
    wr(cw(3, 0, 0, 0, 0, 0, 1));
    run(4'h1, 6);
    chk("R8 descending before clear", count_down, 1);
    wr(cw(3, 0, 0, 0, 0, 0, 1));
    chk("R9 dir reset", count_down, 0);
    chk("R9 updn count cleared", count, 0);
    run(4'h1, 1);
    chk("R9 counts up after clear", count, 1);

    // R10 interrupt gating, R6 software clear
    top_val = 16'd2;
    wr(cw(1, 0, 0, 0, 1, 0, 1));
    run(4'h1, 3);
    chk("R6 flag set", ovf_flag, 1);
    chk("R10 irq on", irq, 1);
    wr(cw(1, 0, 0, 0, 1, 0, 0));
    chk("R6 flag cleared by write", ovf_flag, 0);
    chk("R10 irq off", irq, 0);
    chk("R6 clear keeps count", count, 0);
    wr(cw(1, 0, 0, 0, 0, 1, 0));
    chk("R6 flag written 1", ovf_flag, 1);
    chk("R10 irq masked", irq, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule